// File: doc/BRIEF.md
# Background Offset Calibration Engine

This block sits behind a 10-bit time-interleaved converter and removes a slowly drifting offset from every conversion result in the digital domain. A free-running timer divides time into calibration periods. During each period the engine collects signed offset measurements from a reference conversion path. This path sits where it sees the same temperature drift as all working slices. The engine averages the measurements, negates the average to form a signed correction, and adds that correction to each raw code.

Conversions never stop for calibration. Raw codes keep flowing with their strobe, and each one leaves one cycle later, corrected and marked by an end-of-conversion pulse. A new correction is adopted only on the last clock of a calibration period, so the output never changes gain or offset partway through a period. An asynchronous, active-high bypass pin is brought into the clock domain through two flops. While it is set, raw codes leave unchanged. Measurement continues underneath, so releasing bypass returns to the most recently latched correction.

Top module: `ofs_cal_engine`

## Requirements
- R1: While reset is low, and after it, `cor_data` is 0, `eoc` is low and the correction factor is 0, so conversions before the first completed calibration pass with their value unchanged.
- R2: Every cycle where `raw_vld` is high produces exactly one cycle of `eoc` high on the next clock edge, with the result valid on `cor_data` in that cycle. `eoc` is low in every other cycle.
- R3: When not bypassed, `cor_data` = raw code + factor. The factor is the negated average of 16 accepted reference samples, where the average is the sum divided by 16 rounded toward minus infinity (arithmetic shift). Offsets of either sign are corrected.
- R4: The corrected sum saturates at 0 below and at 1023 above. It never wraps.
- R5: The factor changes only on the clock edge that ends a calibration period. Periods are CAL_PERIOD cycles long and are counted from reset release, so the edges are the CAL_PERIOD-th, the 2·CAL_PERIOD-th, and so on. A conversion strobed in the last cycle of a period still uses the old factor.
- R6: Within a period, a reference sample (`ref_vld` high, `ref_ofs` an 8-bit two's-complement value) is accepted only before the last cycle of the period and only up to the 16th sample. A period that ends with fewer than 16 accepted samples keeps the previous factor.
- R7: `cal_bypass` high, after its two-flop synchroniser (it affects conversions strobed from the third rising edge after it is set), makes `cor_data` equal the raw code.
- R8: While bypassed, calibration keeps running and latching factors. After bypass is released, corrections use the most recently latched factor.
- R9: Conversions strobed in the same cycles as reference samples are processed without loss or delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_data | input | 10 | Raw conversion code |
| raw_vld | input | 1 | Strobe for raw_data |
| ref_ofs | input | 8 | Signed offset measured on the reference path |
| ref_vld | input | 1 | Strobe for ref_ofs |
| cal_bypass | input | 1 | Asynchronous active-high calibration bypass |
| cor_data | output | 10 | Corrected (or bypassed) code |
| eoc | output | 1 | End of conversion; cor_data valid while high |

## Verification
The bench probes the period boundary from both sides. A conversion strobed in the final cycle must still carry the old correction, and the very next one must carry the new correction. A design that latches one cycle early or late fails on exactly one of these two codes. Codes near 0 and 1023 are sent under corrections of both signs, so a wrapping adder turns a clamp into a code near the opposite rail. The bench also runs periods that are short by one sample, or whose 16th sample arrives in the final cycle, or that receive extra samples after the 16th. A sample counter that is off by one, or that does not cap, then latches a visibly wrong factor. A factor of +128, from a −128 average, is latched during bypass and checked after release. This catches a narrow factor register, and also a bypass that freezes or clears calibration.

// File: rtl/ofs_cal_pkg.sv
// Shared types for the background offset calibration engine.
package ofs_cal_pkg;

    // Selects which value drives the output register.
    typedef enum logic {
        PATH_CORRECTED = 1'b0,
        PATH_RAW       = 1'b1
    } out_path_e;

endpackage

// File: rtl/ofs_cal_sync.sv
// Two-flop synchroniser for a level input that arrives without relation to clk.
// Assumes the input is a slowly changing level; reset clears both stages.
module ofs_cal_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic stage1;
    logic stage2;

    // Shift the asynchronous level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= 1'b0;
            stage2 <= 1'b0;
        end else begin
            stage1 <= async_in;
            stage2 <= stage1;
        end
    end

    assign sync_out = stage2;
endmodule

// File: rtl/ofs_cal_timer.sv
// Free-running calibration period timer. Flags the last cycle of each period.
// Assumes CAL_PERIOD >= 2; the count restarts from zero at reset release.
module ofs_cal_timer #(
    parameter int CAL_PERIOD = 256
) (
    input  logic clk,
    input  logic rst_n,
    output logic period_last
);
    localparam int CNT_W = (CAL_PERIOD > 2) ? $clog2(CAL_PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CAL_PERIOD - 1);

    logic [CNT_W-1:0] phase;

    // Count cycles within the period and wrap on its last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)           phase <= '0;
        else if (period_last) phase <= '0;
        else                  phase <= phase + 1'b1;
    end

    assign period_last = (phase == LAST);

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        period_last |=> (phase == '0)); // R5
endmodule

// File: rtl/ofs_cal_meas.sv
// Offset measurement: accumulates reference samples over one period, then
// latches the negated floor-average as the signed correction factor.
// Assumes ref_ofs is two's complement; a short period keeps the old factor.
module ofs_cal_meas #(
    parameter int AVG_LOG2 = 4,
    parameter int OFS_W    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    period_last,
    input  logic signed [OFS_W-1:0] ref_ofs,
    input  logic                    ref_vld,
    output logic signed [OFS_W:0]   factor
);
    localparam int SAMPLES = 1 << AVG_LOG2;
    localparam int SUM_W   = OFS_W + AVG_LOG2;
    localparam int SCNT_W  = AVG_LOG2 + 1;
    localparam logic [SCNT_W-1:0] FULL = SCNT_W'(SAMPLES);

    logic [SCNT_W-1:0]       n_taken;
    logic signed [SUM_W-1:0] acc;
    logic signed [SUM_W-1:0] avg;
    logic signed [OFS_W:0]   neg_avg;
    logic                    take;

    // Accept a sample only before the last cycle and until the window is full.
    always_comb begin
        take    = ref_vld && !period_last && (n_taken < FULL);
        avg     = acc >>> AVG_LOG2;
        neg_avg = -((OFS_W + 1)'(avg));
    end

    // Accumulate accepted samples; clear on the period's last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || period_last) begin
            acc     <= '0;
            n_taken <= '0;
        end else if (take) begin
            acc     <= acc + SUM_W'(ref_ofs);
            n_taken <= n_taken + 1'b1;
        end
    end

    // Latch a new factor only at the trailing edge of a complete period.
    always_ff @(posedge clk) begin
        if (!rst_n)                             factor <= '0;
        else if (period_last && n_taken == FULL) factor <= neg_avg;
    end

    AST_SAMPLE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        n_taken <= FULL); // R6
    AST_FACTOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !period_last |=> $stable(factor)); // R5
endmodule

// File: rtl/ofs_cal_apply.sv
// Applies the correction factor to each raw code, clamps to the code range,
// and registers the result together with the end-of-conversion pulse.
// Assumes bypass_s is already synchronous to clk.
module ofs_cal_apply
    import ofs_cal_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int FAC_W  = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DATA_W-1:0]       raw_data,
    input  logic                    raw_vld,
    input  logic signed [FAC_W-1:0] factor,
    input  logic                    bypass_s,
    output logic [DATA_W-1:0]       cor_data,
    output logic                    eoc
);
    localparam int SW = ((DATA_W > FAC_W) ? DATA_W : FAC_W) + 2;
    localparam logic signed [SW-1:0] CODE_MAX = SW'((1 << DATA_W) - 1);

    logic signed [SW-1:0] total;
    logic [DATA_W-1:0]    clamped;
    out_path_e            path;

    // Add the signed factor to the zero-extended code and clamp both rails.
    always_comb begin
        total = $signed({{(SW - DATA_W){1'b0}}, raw_data}) + SW'(factor);
        if (total < 0)             clamped = '0;
        else if (total > CODE_MAX) clamped = '1;
        else                       clamped = total[DATA_W-1:0];
        path = bypass_s ? PATH_RAW : PATH_CORRECTED;
    end

    // Register the selected value and flag its arrival with eoc.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cor_data <= '0;
            eoc      <= 1'b0;
        end else begin
            eoc <= raw_vld;
            if (raw_vld) cor_data <= (path == PATH_RAW) ? raw_data : clamped;
        end
    end

    AST_EOC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        raw_vld |=> eoc); // R2
    AST_EOC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_vld |=> !eoc); // R2
    AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_vld && bypass_s) |=> (cor_data == $past(raw_data))); // R7
    AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_vld && !bypass_s && factor >= 0) |=> (cor_data >= $past(raw_data))); // R4
    AST_NO_WRAP_DN: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_vld && !bypass_s && factor <= 0) |=> (cor_data <= $past(raw_data))); // R4
endmodule

// File: rtl/ofs_cal_engine.sv
// Top of the background offset calibration engine: period timer, reference
// measurement, bypass synchroniser and the correcting output stage.
// Assumes raw_vld and ref_vld are synchronous to clk; cal_bypass may not be.
module ofs_cal_engine #(
    parameter int DATA_W     = 10,
    parameter int OFS_W      = 8,
    parameter int AVG_LOG2   = 4,
    parameter int CAL_PERIOD = 256
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DATA_W-1:0]       raw_data,
    input  logic                    raw_vld,
    input  logic signed [OFS_W-1:0] ref_ofs,
    input  logic                    ref_vld,
    input  logic                    cal_bypass,
    output logic [DATA_W-1:0]       cor_data,
    output logic                    eoc
);
    localparam int FAC_W = OFS_W + 1;

    logic                    period_last;
    logic                    bypass_s;
    logic signed [FAC_W-1:0] factor;

    ofs_cal_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cal_bypass),
        .sync_out (bypass_s)
    );

    ofs_cal_timer #(.CAL_PERIOD(CAL_PERIOD)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_last (period_last)
    );

    ofs_cal_meas #(.AVG_LOG2(AVG_LOG2), .OFS_W(OFS_W)) u_meas (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_last (period_last),
        .ref_ofs     (ref_ofs),
        .ref_vld     (ref_vld),
        .factor      (factor)
    );

    ofs_cal_apply #(.DATA_W(DATA_W), .FAC_W(FAC_W)) u_apply (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_data (raw_data),
        .raw_vld  (raw_vld),
        .factor   (factor),
        .bypass_s (bypass_s),
        .cor_data (cor_data),
        .eoc      (eoc)
    );
endmodule

// File: tb/ofs_cal_engine_tb.sv
module ofs_cal_engine_tb;
    localparam int P = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [9:0]        raw_data = '0;
    logic              raw_vld = 1'b0;
    logic signed [7:0] ref_ofs = '0;
    logic              ref_vld = 1'b0;
    logic              cal_bypass = 1'b0;
    logic [9:0]        cor_data;
    logic              eoc;

    always #5 clk = ~clk;

    ofs_cal_engine #(.CAL_PERIOD(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .raw_data(raw_data), .raw_vld(raw_vld),
        .ref_ofs(ref_ofs), .ref_vld(ref_vld), .cal_bypass(cal_bypass),
        .cor_data(cor_data), .eoc(eoc)
    );

    typedef struct { int v; string tag; } exp_t;
    exp_t q[$];
    int total = 0, bad = 0;
    int edge_n;
    int mf = 0, pend_sum = 0, pend_cnt = 0;
    bit mbyp = 0;

    always @(posedge clk) if (!rst_n) edge_n <= 0; else edge_n <= edge_n + 1;

    function automatic int model_out(int raw);
        int s;
        if (mbyp) return raw;
        s = raw + mf;
        if (s < 0) s = 0;
        if (s > 1023) s = 1023;
        return s;
    endfunction

    task automatic check(string tag, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Monitor: pop the expected item for every eoc.
    always @(negedge clk) begin
        if (rst_n && eoc) begin
            if (q.size() == 0) check("R2 eoc without strobe", 1, 0);
            else begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, int'(cor_data), e.v);
            end
        end
    end

    // Driver: one cycle starting and ending at a falling edge.
    task automatic cyc(bit rv, int rval, bit wv, int raw, string tag);
        bit last;
        ref_vld = rv; ref_ofs = 8'(rval); raw_vld = wv; raw_data = 10'(raw);
        if (wv) q.push_back('{model_out(raw), tag});
        last = ((edge_n % P) == P - 1);
        if (rv && !last && pend_cnt < 16) begin pend_sum += rval; pend_cnt++; end
        @(negedge clk);
        ref_vld = 0; raw_vld = 0;
        if (last) begin
            if (pend_cnt == 16) mf = -(pend_sum >>> 4);
            pend_sum = 0; pend_cnt = 0;
        end
    endtask

    task automatic idle(int n);
        repeat (n) cyc(0, 0, 0, 0, "");
    endtask

    task automatic to_phase(int ph);
        while ((edge_n % P) != ph) cyc(0, 0, 0, 0, "");
    endtask

    task automatic send(int raw, string tag);
        cyc(0, 0, 1, raw, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog expired", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset cor_data", int'(cor_data), 0);
        check("R1 reset eoc", int'(eoc), 0);
        rst_n = 1'b1;
        send(500, "R1 zero factor after reset");
        send(0, "R1 zero factor low code");
        send(1023, "R1 zero factor high code");
        idle(1);
        check("R2 eoc low when idle", int'(eoc), 0);

        // +3 offset: factor -3, adopted only at the boundary.
        to_phase(0);
        for (int i = 0; i < 16; i++) cyc(1, 3, i == 5, 600, "R5 mid-period keeps old factor");
        to_phase(P - 1);
        send(700, "R5 last cycle uses old factor");
        send(700, "R3 positive offset removed");
        send(2, "R4 clamp at zero");
        send(3, "R4 clamp exact zero");
        send(4, "R4 small code corrected");

        // -9.5 average floors to -10: factor +10; conversions every cycle.
        to_phase(0);
        for (int i = 0; i < 16; i++) cyc(1, (i % 2) ? -9 : -10, 1, 200 + i, "R9 conversion during calibration");
        to_phase(P - 1);
        idle(1);
        send(100, "R3 negative offset removed");
        send(1020, "R4 clamp at 1023");
        send(1012, "R4 just below top");

        // Short period keeps the factor.
        to_phase(0);
        for (int i = 0; i < 10; i++) cyc(1, 50, 0, 0, "");
        to_phase(P - 1); idle(1);
        send(100, "R6 short period keeps factor");

        // Extra samples beyond 16 ignored.
        to_phase(0);
        for (int i = 0; i < 16; i++) cyc(1, 0, 0, 0, "");
        for (int i = 0; i < 5; i++) cyc(1, 100, 0, 0, "");
        to_phase(P - 1); idle(1);
        send(50, "R6 samples after 16th ignored");

        // 15 samples plus one on the final cycle: not a full window.
        to_phase(P - 16);
        for (int i = 0; i < 15; i++) cyc(1, 40, 0, 0, "");
        cyc(1, 40, 0, 0, "");
        idle(1);
        send(300, "R6 final-cycle sample ignored");

        // Set a factor of -20, then bypass.
        to_phase(0);
        for (int i = 0; i < 16; i++) cyc(1, 20, 0, 0, "");
        to_phase(P - 1); idle(1);
        send(100, "R3 factor -20 applied");
        cal_bypass = 1'b1;
        idle(3); mbyp = 1;
        send(100, "R7 bypass passes raw");
        to_phase(0);
        for (int i = 0; i < 16; i++) cyc(1, -128, 0, 0, "");
        to_phase(P - 1); idle(1);
        send(900, "R7 bypass ignores new factor");
        cal_bypass = 1'b0;
        idle(3); mbyp = 0;
        send(5, "R8 factor +128 latched during bypass");
        send(1000, "R8 release clamps with new factor");
        idle(2);
        check("R2 every strobe produced eoc", q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule